// File: doc/BRIEF.md
# Gated Timer with Edge-Selective Reload

This block is a 16-bit up-timer that can also split into two independent 8-bit timers. It advances on a clock-enable strobe (timer mode) or on rising edges of an external pin (counter mode). When a gate bit is set, the same pin can hold the count still while it is low. Gating needs the pin to be a pure input and the block to be in timer mode. In split mode, gating acts on the upper timer only.

Both edges of the synchronized pin can trigger a capture of the running count, and can also reload the count from a reload register. When capture and reload are armed on both edges, the gate bit takes a new meaning. It then lets the polarity bit name one edge that captures but does not reload. Overflow reloads the timer and raises a sticky flag, which is cleared by writing 1.

Top module: `gated_timer`

## Requirements
- R1: On reset every register clears: the count, the capture value, the reload value, all flags and the control word, which reads back 0. Control bits: [0] gate, [1] run, [2] split, [3] counter mode, [4] pin drives out, [5] polarity, [6] reload on edge, [8:7] edge select.
- R2: In 16-bit mode with run=1 and timer mode, the count advances by one on each cycle with `tick_en` high. From FFFFh it loads the reload value instead and sets `ovf_hi`.
- R3: In split mode each byte counts on its own. A byte at FFh loads its byte of the reload value. The low byte sets `ovf_lo` and the high byte sets `ovf_hi`.
- R4: With gate=1, pin-out=0 and timer mode, the 16-bit count advances only while the two-flop-synchronized pin is high. A pin level change takes effect on the count at the third rising clock edge after the change.
- R5: In split mode with gating active, only the high byte is held by a low pin. The low byte is never gated.
- R6: When pin-out=1 or counter mode is selected, the gate bit has no gating effect.
- R7: In counter mode with run=1, the count advances once per rising edge of the synchronized pin, and `tick_en` is ignored.
- R8: Edge select 00 disables capture, 01 selects rising, 10 selects falling and 11 selects both. On a selected edge, `capture_q` takes the count from before that cycle's update and `cap_flag` sets.
- R9: With reload-on-edge=1, a selected edge loads the count from the reload register. This load takes priority over counting and overflow.
- R10: With edge select 11, reload-on-edge=1 and gate=1, polarity 0 suppresses the reload on falling edges and polarity 1 suppresses it on rising edges. Gating is off in this configuration.
- R11: `ovf_hi`, `ovf_lo` and `cap_flag` are sticky. `ovf_clr[1]`, `ovf_clr[0]` and `cap_clr` clear them, and a new set event in the same cycle wins over a clear.
- R12: `count_we` loads the count directly, and this load takes priority over edge reload and counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled count strobe for timer mode |
| pin_in | input | 1 | External pin, asynchronous |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 9 | Control word write data |
| ctrl_q | output | 9 | Control word readback |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | W | Reload register write data |
| count_we | input | 1 | Direct count write strobe |
| count_wdata | input | W | Direct count write data |
| ovf_clr | input | 2 | Write-1 clear: [1] high or 16-bit overflow, [0] low-byte overflow |
| cap_clr | input | 1 | Write-1 clear of the capture flag |
| count_q | output | W | Current count |
| capture_q | output | W | Last captured count |
| ovf_hi | output | 1 | Sticky overflow, 16-bit or high byte |
| ovf_lo | output | 1 | Sticky overflow, low byte in split mode |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
A write, a strobe or a count-enable shows on the outputs after one rising edge. A pin change passes two synchronizer flops and an edge-history flop, so gating, counting, capture and edge reload react to it at the third rising edge. The bench's reference model keeps a three-deep history of sampled pin values to reproduce exactly that latency. All inputs change just after a falling edge and the model is stepped at the rising edge. Every output is compared at the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/gated_timer.sv
module gated_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         pin_in,
  input  logic         ctrl_we,
  input  logic [8:0]   ctrl_wdata,
  output logic [8:0]   ctrl_q,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         count_we,
  input  logic [W-1:0] count_wdata,
  input  logic [1:0]   ovf_clr,
  input  logic         cap_clr,
  output logic [W-1:0] count_q,
  output logic [W-1:0] capture_q,
  output logic         ovf_hi,
  output logic         ovf_lo,
  output logic         cap_flag
);
  localparam int H = W / 2;

  logic [8:0]   ctrl;
  logic [W-1:0] cnt, rld, cap, nxt;
  logic         s1, s2, s3;
  logic         set_hi, set_lo;

  wire       gate_en  = ctrl[0];
  wire       run      = ctrl[1];
  wire       split    = ctrl[2];
  wire       cnt_mode = ctrl[3];
  wire       pin_oe   = ctrl[4];
  wire       edge_pol = ctrl[5];
  wire       rl_en    = ctrl[6];
  wire [1:0] edge_sel = ctrl[8:7];

  wire rise    = s2 & ~s3;
  wire fall    = ~s2 & s3;
  wire both    = (edge_sel == 2'b11);
  wire special = gate_en & both & rl_en;
  wire gate_ok = gate_en & ~pin_oe & ~cnt_mode & ~(both & rl_en);
  wire cap_evt = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  wire no_rl   = special & (edge_pol ? rise : fall);
  wire edge_rl = rl_en & cap_evt & ~no_rl;
  wire inc_lo  = run & (cnt_mode ? rise : tick_en);
  wire inc_hi  = inc_lo & (~gate_ok | s2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    nxt    = cnt;
    set_hi = 1'b0;
    set_lo = 1'b0;
    if (count_we) begin
      nxt = count_wdata;
    end else if (edge_rl) begin
      nxt = rld;
    end else if (!split) begin
      if (inc_hi) begin
        if (&cnt) begin
          nxt    = rld;
          set_hi = 1'b1;
        end else begin
          nxt = cnt + 1'b1;
        end
      end
    end else begin
      if (inc_lo) begin
        if (&cnt[H-1:0]) begin
          nxt[H-1:0] = rld[H-1:0];
          set_lo     = 1'b1;
        end else begin
          nxt[H-1:0] = cnt[H-1:0] + 1'b1;
        end
      end
      if (inc_hi) begin
        if (&cnt[W-1:H]) begin
          nxt[W-1:H] = rld[W-1:H];
          set_hi     = 1'b1;
        end else begin
          nxt[W-1:H] = cnt[W-1:H] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      rld      <= '0;
      cnt      <= '0;
      cap      <= '0;
      ovf_hi   <= 1'b0;
      ovf_lo   <= 1'b0;
      cap_flag <= 1'b0;
    end else begin
      if (ctrl_we)   ctrl <= ctrl_wdata;
      if (reload_we) rld  <= reload_wdata;
      cnt      <= nxt;
      if (cap_evt) cap <= cnt;
      ovf_hi   <= set_hi | (ovf_hi & ~ovf_clr[1]);
      ovf_lo   <= set_lo | (ovf_lo & ~ovf_clr[0]);
      cap_flag <= cap_evt | (cap_flag & ~cap_clr);
    end
  end

  assign ctrl_q    = ctrl;
  assign count_q   = cnt;
  assign capture_q = cap;

  assert_gated_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ok && !s2 && !split && !count_we && !edge_rl) |=> $stable(count_q));

  assert_low_byte_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && split && !cnt_mode && !count_we && !edge_rl)
      |=> (count_q[H-1:0] != $past(count_q[H-1:0])));

  assert_capture_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (capture_q == $past(count_q)) && cap_flag);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hi && !ovf_clr[1]) |=> ovf_hi);

  assert_direct_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count_we |=> (count_q == $past(count_wdata)));
endmodule

// File: tb/gated_timer_tb.sv
module gated_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, pin_in = 1'b0;
  logic        ctrl_we = 1'b0, reload_we = 1'b0, count_we = 1'b0, cap_clr = 1'b0;
  logic [8:0]  ctrl_wdata = '0;
  logic [15:0] reload_wdata = '0, count_wdata = '0;
  logic [1:0]  ovf_clr = '0;
  logic [8:0]  ctrl_q;
  logic [15:0] count_q, capture_q;
  logic        ovf_hi, ovf_lo, cap_flag;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  localparam int GATE = 1, RUN = 2, SPLIT = 4, CNT = 8, OE = 16, POL = 32, RL = 64;
  localparam int E_RISE = 128, E_FALL = 256, E_BOTH = 384;

  always #4 clk = ~clk;

  gated_timer #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_in(pin_in),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .count_we(count_we), .count_wdata(count_wdata),
    .ovf_clr(ovf_clr), .cap_clr(cap_clr),
    .count_q(count_q), .capture_q(capture_q),
    .ovf_hi(ovf_hi), .ovf_lo(ovf_lo), .cap_flag(cap_flag)
  );

  int m_ctrl, m_rld, m_cnt, m_cap, m_ohi, m_olo, m_cf;
  int hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rld = 0; m_cnt = 0; m_cap = 0;
      m_ohi = 0; m_olo = 0; m_cf = 0;
      hist = '{0, 0, 0};
    end else begin
      int lvl, old, rise, fall, sel, both, gate_ok, evt, rl, inc, inc_g, lo, hi, shi, slo;
      lvl  = hist[1];
      old  = hist[0];
      rise = (lvl == 1 && old == 0);
      fall = (lvl == 0 && old == 1);
      sel  = (m_ctrl >> 7) & 3;
      both = (sel == 3);
      gate_ok = (m_ctrl & GATE) != 0 && (m_ctrl & OE) == 0 && (m_ctrl & CNT) == 0
                && !(both && (m_ctrl & RL) != 0);
      evt  = ((sel & 1) != 0 && rise) || ((sel & 2) != 0 && fall);
      rl   = (m_ctrl & RL) != 0 && evt;
      if (both && (m_ctrl & RL) != 0 && (m_ctrl & GATE) != 0) begin
        if ((m_ctrl & POL) != 0 && rise) rl = 0;
        if ((m_ctrl & POL) == 0 && fall) rl = 0;
      end
      inc   = (m_ctrl & RUN) != 0 && ((m_ctrl & CNT) != 0 ? rise : tick_en);
      inc_g = inc && (!gate_ok || lvl == 1);
      shi = 0; slo = 0;
      old = m_cnt;
      if (count_we) m_cnt = count_wdata;
      else if (rl) m_cnt = m_rld;
      else if ((m_ctrl & SPLIT) == 0) begin
        if (inc_g) begin
          if (m_cnt == 65535) begin m_cnt = m_rld; shi = 1; end
          else m_cnt = m_cnt + 1;
        end
      end else begin
        lo = m_cnt % 256; hi = m_cnt / 256;
        if (inc) begin
          if (lo == 255) begin lo = m_rld % 256; slo = 1; end else lo = lo + 1;
        end
        if (inc_g) begin
          if (hi == 255) begin hi = m_rld / 256; shi = 1; end else hi = hi + 1;
        end
        m_cnt = hi * 256 + lo;
      end
      if (evt) begin m_cap = old; m_cf = 1; end
      else if (cap_clr) m_cf = 0;
      m_ohi = shi ? 1 : (ovf_clr[1] ? 0 : m_ohi);
      m_olo = slo ? 1 : (ovf_clr[0] ? 0 : m_olo);
      if (ctrl_we) m_ctrl = int'(ctrl_wdata);
      if (reload_we) m_rld = int'(reload_wdata);
      hist.push_back(int'(pin_in));
      void'(hist.pop_front());
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("count", int'(count_q), m_cnt);
      cmp("capture", int'(capture_q), m_cap);
      cmp("ovf_hi", int'(ovf_hi), m_ohi);
      cmp("ovf_lo", int'(ovf_lo), m_olo);
      cmp("cap_flag", int'(cap_flag), m_cf);
      cmp("ctrl", int'(ctrl_q), m_ctrl);
    end
  end

  task automatic wr_ctrl(int v);
    @(negedge clk); #1 ctrl_we = 1'b1; ctrl_wdata = 9'(v);
    @(negedge clk); #1 ctrl_we = 1'b0;
  endtask

  task automatic wr_rld(int v);
    @(negedge clk); #1 reload_we = 1'b1; reload_wdata = 16'(v);
    @(negedge clk); #1 reload_we = 1'b0;
  endtask

  task automatic wr_cnt(int v);
    @(negedge clk); #1 count_we = 1'b1; count_wdata = 16'(v);
    @(negedge clk); #1 count_we = 1'b0;
  endtask

  task automatic run_pins(int n, int toggle_div, int clr_div);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      tick_en = ($urandom % 4) != 0;
      if (toggle_div > 0 && ($urandom % toggle_div) == 0) pin_in = ~pin_in;
      ovf_clr = (clr_div > 0 && ($urandom % clr_div) == 0) ? 2'(($urandom % 3) + 1) : 2'b00;
      cap_clr = (clr_div > 0 && ($urandom % clr_div) == 0);
    end
    @(negedge clk); #1 tick_en = 1'b0; ovf_clr = 2'b00; cap_clr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    cmp("reset count", int'(count_q), 0);
    cmp("reset ctrl", int'(ctrl_q), 0);
    cmp("reset flags", int'({ovf_hi, ovf_lo, cap_flag}), 0);
    cmp("reset capture", int'(capture_q), 0);
    #1 rst_n = 1'b1;

    cur_req = "R12";
    wr_rld(16'h1234);
    wr_cnt(16'hFFF0);
    cur_req = "R2";
    wr_ctrl(RUN);
    run_pins(60, 0, 0);
    cur_req = "R11";
    run_pins(40, 0, 3);

    cur_req = "R3";
    wr_rld(16'h5AA5);
    wr_cnt(16'hFEF0);
    wr_ctrl(RUN | SPLIT);
    run_pins(300, 0, 40);

    cur_req = "R4";
    wr_ctrl(RUN | GATE);
    run_pins(200, 6, 0);
    cur_req = "R5";
    wr_ctrl(RUN | GATE | SPLIT);
    run_pins(200, 6, 0);

    cur_req = "R6";
    wr_ctrl(RUN | GATE | OE);
    run_pins(120, 6, 0);
    wr_ctrl(RUN | GATE | CNT);
    run_pins(120, 6, 0);

    cur_req = "R7";
    wr_ctrl(RUN | CNT);
    run_pins(150, 3, 0);

    cur_req = "R8";
    wr_ctrl(RUN);
    run_pins(60, 5, 0);
    wr_ctrl(RUN | E_RISE);
    run_pins(120, 5, 8);
    wr_ctrl(RUN | E_FALL);
    run_pins(120, 5, 8);
    wr_ctrl(RUN | E_BOTH);
    run_pins(120, 5, 8);

    cur_req = "R9";
    wr_rld(16'h0100);
    wr_ctrl(RUN | RL | E_RISE);
    run_pins(150, 7, 0);
    wr_ctrl(RUN | RL | E_BOTH);
    run_pins(150, 7, 0);

    cur_req = "R10";
    wr_rld(16'h4000);
    wr_ctrl(RUN | RL | GATE | E_BOTH);
    run_pins(200, 7, 0);
    wr_ctrl(RUN | RL | GATE | POL | E_BOTH);
    run_pins(200, 7, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule